// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Register Loader

This block holds the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against, and controls every way those values can change. While master reset is held, it samples a load strap and a two-bit select strap. Those three bits pick one of eight default threshold pairs. The load strap alone fixes the programming method for the whole session, either bit-serial or word-parallel.

After reset, the active-low load pin opens access to the registers. In serial mode, one bit is taken from the serial data pin on each clock edge while the serial enable and load are both low. In parallel mode, whole words are taken from the data bus. Writes that arrive through the method not chosen have no effect. Readback is always word-parallel, in either mode. Each access walks a fixed order, almost-empty first and then almost-full. Raising the load pin ends the access and rewinds that order to its start.

The flag comparators are outside this block. They consume `ae_offset` and `af_offset` directly.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rst_n` is low, at each clock edge `ser_mode` takes the level of `cfg_load_n` (1 = serial, 0 = parallel). Both offsets are set to 2^(k+3)-1, truncated to OFF_W bits, where k = {cfg_load_n, cfg_sel[1], cfg_sel[0]} read as a 3-bit number. `rd_data` is cleared to 0.
- R2: Once `rst_n` is high, `ser_mode` does not change, whatever the strap pins do.
- R3: In serial mode, with `cfg_load_n` and `ser_en_n` both low, each clock edge stores `ser_din` at the next chain position. Positions 0..OFF_W-1 fill `ae_offset` from its MSB down to its LSB. Positions OFF_W..2*OFF_W-1 fill `af_offset` the same way. After the last position, the chain wraps to position 0.
- R4: While `ser_en_n` is high, no serial bit is stored and the chain position does not advance.
- R5: In parallel mode, with `cfg_load_n` low, each edge with `par_wr` high stores `par_din`. The first such edge writes `ae_offset`, the next writes `af_offset`, and the two alternate from then on.
- R6: In serial mode `par_wr` changes neither offset. In parallel mode the serial pins change neither offset.
- R7: With `cfg_load_n` low, each edge with `par_rd` high loads `rd_data` with `ae_offset`, then on the next such edge with `af_offset`, alternating. This works in both modes. At all other edges `rd_data` keeps its value.
- R8: While `cfg_load_n` is high, neither offset changes. The serial position, the parallel write order and the read order all return to their start (position 0, almost-empty first).
- R9: When a read and a write happen at the same edge, `rd_data` receives the value the register held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write/read clock, rising edge |
| rst_n | input | 1 | Synchronous active-low master reset |
| cfg_load_n | input | 1 | Reset strap for method; afterwards active-low access enable |
| cfg_sel | input | 2 | Reset strap selecting the default pair together with cfg_load_n |
| ser_en_n | input | 1 | Active-low serial shift enable |
| ser_din | input | 1 | Serial data bit |
| par_wr | input | 1 | Parallel word write request |
| par_din | input | OFF_W | Parallel write data |
| par_rd | input | 1 | Parallel readback request |
| rd_data | output | OFF_W | Registered readback word |
| ae_offset | output | OFF_W | Almost-empty threshold |
| af_offset | output | OFF_W | Almost-full threshold |
| ser_mode | output | 1 | 1 when the serial method was strapped at reset |

## Verification
The hardest situation to reach is a serial chain that is abandoned partway and then restarted. The bench must stop a shift at a position inside `ae_offset` and at another inside `af_offset`, raise load, and confirm that the next bit lands at the almost-empty MSB. Pausing the chain with `ser_en_n` must leave the position where it was. Because the method can only change through reset, the bench resets into each of the eight strap codes in turn, then runs directed and random traffic in both modes. The random traffic includes same-edge reads and writes, and strap pins that toggle after reset.

// File: rtl/fol_pkg.sv
// Package: shared helpers for the flag offset loader.
// Assumes default thresholds are powers of two minus one.
package fol_pkg;

    // Default threshold for strap code k: 2^(k+3)-1
    function automatic logic [31:0] dflt_offset(input logic [2:0] k);
        return (32'd1 << (32'(k) + 32'd3)) - 32'd1;
    endfunction

endpackage

// File: rtl/fol_strap.sv
// Module: captures the programming method while master reset is held.
// Assumes reset is held for at least one clock edge.
module fol_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_load_n,
    output logic ser_mode
);

    // Sample the load strap during reset, freeze it afterwards
    always_ff @(posedge clk) begin
        if (!rst_n)
            ser_mode <= cfg_load_n;
    end

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(ser_mode)); // R2

endmodule

// File: rtl/fol_seq.sv
// Module: access sequencing - serial chain position, parallel write
// order and read order. Everything rewinds while load is high.
// Assumes ser_mode is stable outside reset.
module fol_seq #(
    parameter int OFF_W = 10,
    localparam int CHAIN = 2 * OFF_W,
    localparam int CW = $clog2(CHAIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load_n,
    input  logic          ser_mode,
    input  logic          ser_en_n,
    input  logic          par_wr,
    input  logic          par_rd,
    output logic          ser_we,
    output logic [CW-1:0] ser_pos,
    output logic          par_we,
    output logic          wr_to_af,
    output logic          rd_go,
    output logic          rd_from_af
);

    localparam logic [CW-1:0] LAST = CW'(CHAIN - 1);

    // Qualified strobes: method gating and load gating
    always_comb begin
        ser_we = ser_mode && !cfg_load_n && !ser_en_n;
        par_we = !ser_mode && !cfg_load_n && par_wr;
        rd_go  = !cfg_load_n && par_rd;
    end

    // Serial chain position, wraps after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_load_n)
            ser_pos <= '0;
        else if (ser_we)
            ser_pos <= (ser_pos == LAST) ? '0 : ser_pos + 1'b1;
    end

    // Alternating parallel write target
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_load_n)
            wr_to_af <= 1'b0;
        else if (par_we)
            wr_to_af <= !wr_to_af;
    end

    // Alternating readback source
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_load_n)
            rd_from_af <= 1'b0;
        else if (rd_go)
            rd_from_af <= !rd_from_af;
    end

    AST_REWIND_ON_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load_n |=> (ser_pos == '0 && !wr_to_af && !rd_from_af)); // R8
    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_pos <= LAST); // R3
    AST_POS_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en_n && !cfg_load_n) |=> $stable(ser_pos)); // R4

endmodule

// File: rtl/fol_regs.sv
// Module: the two threshold registers with default load, bit-serial
// update and word-parallel update. Assumes at most one of ser_we and
// par_we is high (method gating upstream guarantees it).
module fol_regs #(
    parameter int OFF_W = 10,
    localparam int CHAIN = 2 * OFF_W,
    localparam int CW = $clog2(CHAIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load_n,
    input  logic [1:0]       cfg_sel,
    input  logic             ser_en_n,
    input  logic             par_wr,
    input  logic             ser_mode,
    input  logic             ser_we,
    input  logic [CW-1:0]    ser_pos,
    input  logic             ser_din,
    input  logic             par_we,
    input  logic             wr_to_af,
    input  logic [OFF_W-1:0] par_din,
    output logic [OFF_W-1:0] ae_q,
    output logic [OFF_W-1:0] af_q
);

    logic [OFF_W-1:0] ae_hit, af_hit;
    logic [OFF_W-1:0] ae_d, af_d;
    logic [2:0]       dflt_code;
    logic [OFF_W-1:0] dflt_val;

    // One-hot bit select per register: position p hits bit OFF_W-1-p
    for (genvar b = 0; b < OFF_W; b++) begin : g_hit
        assign ae_hit[b] = ser_we && (ser_pos == CW'(OFF_W - 1 - b));
        assign af_hit[b] = ser_we && (ser_pos == CW'(CHAIN - 1 - b));
    end

    // Default pair selected by the three strap bits
    always_comb begin
        dflt_code = {cfg_load_n, cfg_sel};
        dflt_val  = OFF_W'(fol_pkg::dflt_offset(dflt_code));
    end

    // Next-state mux: parallel word or serial bit merge
    always_comb begin
        ae_d = (ae_q & ~ae_hit) | (ae_hit & {OFF_W{ser_din}});
        af_d = (af_q & ~af_hit) | (af_hit & {OFF_W{ser_din}});
        if (par_we && !wr_to_af) ae_d = par_din;
        if (par_we &&  wr_to_af) af_d = par_din;
    end

    // Register update with default load during reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_q <= dflt_val;
            af_q <= dflt_val;
        end else begin
            ae_q <= ae_d;
            af_q <= af_d;
        end
    end

    AST_ONE_BIT_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ae_hit, af_hit})); // R3
    AST_LOAD_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load_n |=> ($stable(ae_q) && $stable(af_q))); // R8
    AST_SERIAL_BLOCKS_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && ser_en_n) |=> ($stable(ae_q) && $stable(af_q))); // R6
    AST_PAR_BLOCKS_SER: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && !par_wr) |=> ($stable(ae_q) && $stable(af_q))); // R6

endmodule

// File: rtl/fol_readback.sv
// Module: registered word-parallel readback, returning the value held
// before any same-edge write. Assumes rd_from_af alternates per read.
module fol_readback #(
    parameter int OFF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_go,
    input  logic             rd_from_af,
    input  logic [OFF_W-1:0] ae_q,
    input  logic [OFF_W-1:0] af_q,
    output logic [OFF_W-1:0] rd_data
);

    // Capture the selected register on a qualified read
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_go)
            rd_data <= rd_from_af ? af_q : ae_q;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data)); // R7

endmodule

// File: rtl/flag_offset_loader.sv
// Module: top of the almost-empty/almost-full threshold loader.
// Strap capture, access sequencing, storage and readback are separate
// blocks. Single clock; all strap decoding happens while rst_n is low.
module flag_offset_loader #(
    parameter int OFF_W = 10,
    localparam int CW = $clog2(2 * OFF_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load_n,
    input  logic [1:0]       cfg_sel,
    input  logic             ser_en_n,
    input  logic             ser_din,
    input  logic             par_wr,
    input  logic [OFF_W-1:0] par_din,
    input  logic             par_rd,
    output logic [OFF_W-1:0] rd_data,
    output logic [OFF_W-1:0] ae_offset,
    output logic [OFF_W-1:0] af_offset,
    output logic             ser_mode
);

    logic          ser_we, par_we, wr_to_af, rd_go, rd_from_af;
    logic [CW-1:0] ser_pos;

    fol_strap u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load_n (cfg_load_n),
        .ser_mode   (ser_mode)
    );

    fol_seq #(.OFF_W(OFF_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load_n (cfg_load_n),
        .ser_mode   (ser_mode),
        .ser_en_n   (ser_en_n),
        .par_wr     (par_wr),
        .par_rd     (par_rd),
        .ser_we     (ser_we),
        .ser_pos    (ser_pos),
        .par_we     (par_we),
        .wr_to_af   (wr_to_af),
        .rd_go      (rd_go),
        .rd_from_af (rd_from_af)
    );

    fol_regs #(.OFF_W(OFF_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load_n (cfg_load_n),
        .cfg_sel    (cfg_sel),
        .ser_en_n   (ser_en_n),
        .par_wr     (par_wr),
        .ser_mode   (ser_mode),
        .ser_we     (ser_we),
        .ser_pos    (ser_pos),
        .ser_din    (ser_din),
        .par_we     (par_we),
        .wr_to_af   (wr_to_af),
        .par_din    (par_din),
        .ae_q       (ae_offset),
        .af_q       (af_offset)
    );

    fol_readback #(.OFF_W(OFF_W)) u_rb (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_go      (rd_go),
        .rd_from_af (rd_from_af),
        .ae_q       (ae_offset),
        .af_q       (af_offset),
        .rd_data    (rd_data)
    );

endmodule

// File: tb/tb_flag_offset_loader.sv
`timescale 1ns/1ps
module tb_flag_offset_loader;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load_n = 1'b1;
    logic [1:0] cfg_sel = 2'b00;
    logic ser_en_n = 1'b1, ser_din = 1'b0, par_wr = 1'b0, par_rd = 1'b0;
    logic [W-1:0] par_din = '0;
    logic [W-1:0] rd_data, ae_offset, af_offset;
    logic ser_mode;

    flag_offset_loader #(.OFF_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load_n(cfg_load_n), .cfg_sel(cfg_sel),
        .ser_en_n(ser_en_n), .ser_din(ser_din), .par_wr(par_wr),
        .par_din(par_din), .par_rd(par_rd), .rd_data(rd_data),
        .ae_offset(ae_offset), .af_offset(af_offset), .ser_mode(ser_mode)
    );

    always #2.5 clk = ~clk;

    int total = 0, bad = 0, cycles = 0;
    string tag = "R1";
    bit done = 0;

    // Behavioural reference state
    logic [W-1:0] m_ae, m_af, m_rd;
    logic m_mode;
    int m_pos, m_wsel, m_rsel;

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Advance reference by one edge using the inputs held at that edge
    task automatic model_edge();
        logic [W-1:0] old_ae, old_af, dv;
        int k;
        old_ae = m_ae; old_af = m_af;
        if (!rst_n) begin
            k = {cfg_load_n, cfg_sel};
            dv = W'((1 << (k + 3)) - 1);
            m_mode = cfg_load_n; m_ae = dv; m_af = dv; m_rd = '0;
            m_pos = 0; m_wsel = 0; m_rsel = 0;
        end else if (cfg_load_n) begin
            m_pos = 0; m_wsel = 0; m_rsel = 0;
        end else begin
            if (par_rd) begin
                m_rd = (m_rsel != 0) ? old_af : old_ae;
                m_rsel ^= 1;
            end
            if (m_mode && !ser_en_n) begin
                if (m_pos < W) m_ae[W-1-m_pos] = ser_din;
                else           m_af[2*W-1-m_pos] = ser_din;
                m_pos = (m_pos + 1) % (2 * W);
            end
            if (!m_mode && par_wr) begin
                if (m_wsel == 0) m_ae = par_din; else m_af = par_din;
                m_wsel ^= 1;
            end
        end
    endtask

    // One clock: edge, reference update, compare all outputs
    task automatic tick();
        @(posedge clk);
        #1;
        cycles++;
        model_edge();
        chk("ae_offset", int'(ae_offset), int'(m_ae));
        chk("af_offset", int'(af_offset), int'(m_af));
        chk("rd_data",   int'(rd_data),   int'(m_rd));
        chk("ser_mode",  int'(ser_mode),  int'(m_mode));
    endtask

    task automatic idle_in();
        ser_en_n = 1'b1; par_wr = 1'b0; par_rd = 1'b0;
    endtask

    task automatic do_reset(input logic ld, input logic [1:0] sel);
        tag = "R1";
        idle_in();
        rst_n = 1'b0; cfg_load_n = ld; cfg_sel = sel;
        tick(); tick();
        rst_n = 1'b1; cfg_load_n = 1'b1;
        tick();
    endtask

    task automatic ser_bits(input int n, input logic [31:0] pat);
        cfg_load_n = 1'b0; ser_en_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            ser_din = pat[i % 32];
            tick();
        end
        ser_en_n = 1'b1;
    endtask

    task automatic pwrite(input logic [W-1:0] v);
        cfg_load_n = 1'b0; par_wr = 1'b1; par_din = v;
        tick();
        par_wr = 1'b0;
    endtask

    task automatic pread();
        cfg_load_n = 1'b0; par_rd = 1'b1;
        tick();
        par_rd = 1'b0;
    endtask

    initial begin : watchdog
        #(5 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: every strap code
        for (int k = 0; k < 8; k++) do_reset(k[2], k[1:0]);

        // Parallel mode
        do_reset(1'b0, 2'b10);
        tag = "R5"; pwrite(10'd37); pwrite(10'd500); pwrite(10'd11);
        tag = "R7"; cfg_load_n = 1'b1; tick(); pread(); pread(); pread();
        tag = "R6"; cfg_load_n = 1'b0; ser_bits(7, 32'hFFFF_FFFF);
        tag = "R8"; cfg_load_n = 1'b1; tick(); pwrite(10'd99);
        cfg_load_n = 1'b1; tick(); pwrite(10'd123);
        tag = "R9"; cfg_load_n = 1'b1; tick();
        cfg_load_n = 1'b0; par_rd = 1'b1; par_wr = 1'b1; par_din = 10'd777; tick();
        idle_in();
        tag = "R2"; cfg_load_n = 1'b1; cfg_sel = 2'b11; tick(); tick();

        // Serial mode
        do_reset(1'b1, 2'b01);
        tag = "R3"; ser_bits(2 * W, 32'hA5C3_9E17);
        cfg_load_n = 1'b1; tick();
        tag = "R7"; pread(); pread();
        tag = "R6"; cfg_load_n = 1'b1; tick(); pwrite(10'd5); pwrite(10'd6);
        tag = "R4"; cfg_load_n = 1'b1; tick(); ser_bits(4, 32'h0);
        ser_en_n = 1'b1; ser_din = 1'b1; tick(); tick();
        ser_bits(3, 32'hFFFF_FFFF);
        tag = "R8"; cfg_load_n = 1'b1; tick(); ser_bits(2, 32'h0);
        cfg_load_n = 1'b1; tick(); ser_bits(W + 4, 32'h0F0F_3333);
        cfg_load_n = 1'b1; tick();
        tag = "R3"; ser_bits(3 * W, 32'h1234_5678);
        tag = "R2"; cfg_load_n = 1'b0; tick(); cfg_load_n = 1'b1; tick();

        // Random traffic in both modes
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0], 2'(m + 1));
            tag = "R9";
            for (int i = 0; i < 3000; i++) begin
                cfg_load_n = ($urandom % 6) == 0;
                cfg_sel    = 2'($urandom);
                ser_en_n   = $urandom % 2;
                ser_din    = $urandom % 2;
                par_wr     = $urandom % 2;
                par_rd     = $urandom % 2;
                par_din    = W'($urandom);
                tick();
            end
            idle_in();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule